// File: doc/BRIEF.md
# Program Counter Vector Sequencer

This block owns the program counter of a small microcontroller core whose program space is 2048 bytes of mask ROM, so the counter is 11 bits wide and never leaves that space. At every instruction boundary, marked by the advance strobe, it picks the next fetch address. The choices are the next sequential address, a jump target supplied by the decoder, or one of two fixed interrupt entry points. Reset always restarts execution at address 0.

An interrupt taken at a boundary acts like a subroutine call. In the same cycle that the counter loads the entry point, the block raises a one-cycle push request to the return stack unit. The push carries the address that would otherwise have run next. The external interrupt line is a level input. A timer overflow is a single-cycle strobe, so it is latched as pending until the timer interrupt is taken. Each source has its own enable. Once either interrupt is entered, no further interrupt is accepted until a return-from-interrupt pulse arrives.

Top module: `pc_vector_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_addr_o` is 0 and `push_o` is 0. Reset also clears the in-service state and any pending timer request. The first fetch after release is address 0.
- R2: On a cycle with `adv_i` high, no jump and no interrupt taken, `fetch_addr_o` becomes the old value plus one, modulo 2048 (2047 is followed by 0).
- R3: On a cycle with `adv_i` high and `jump_i` high and no interrupt taken, `fetch_addr_o` becomes `jump_addr_i` on the following cycle.
- R4: When `adv_i`, `ext_irq_i` and `ext_en_i` are all high and no service is in progress, `fetch_addr_o` becomes 3 on the next cycle. With `ext_en_i` low, the external line has no effect.
- R5: A one-cycle pulse on `tmr_ovf_i` sets a pending flag. The flag stays set while `tmr_en_i` is low. It is taken at a boundary when `tmr_en_i` is high and no service is in progress: `fetch_addr_o` becomes 7 and the flag clears.
- R6: In the cycle an interrupt vector appears on `fetch_addr_o`, `push_o` is high for exactly that one cycle. `push_addr_o` then equals `jump_addr_i` if a jump was requested at that boundary, and the old counter plus one otherwise.
- R7: If an external request and a pending timer request meet at the same boundary, the external one is taken (address 3) and the timer request remains pending.
- R8: Once an interrupt is entered, no interrupt is accepted until a cycle with `reti_i` high. Acceptance resumes from the cycle after that pulse.
- R9: With `adv_i` low, `fetch_addr_o` holds, `push_o` stays low, and interrupt requests are neither taken nor lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Instruction boundary / advance strobe |
| jump_i | input | 1 | Load `jump_addr_i` at this boundary |
| jump_addr_i | input | 11 | Jump target |
| ext_irq_i | input | 1 | External interrupt request, level |
| ext_en_i | input | 1 | External interrupt enable |
| tmr_ovf_i | input | 1 | Timer/counter overflow strobe |
| tmr_en_i | input | 1 | Timer interrupt enable |
| reti_i | input | 1 | Return-from-interrupt pulse |
| fetch_addr_o | output | 11 | Current fetch address (program counter) |
| push_o | output | 1 | Return-address push request |
| push_addr_o | output | 11 | Return address for the stack unit |

## Verification
A corrupted counter shows up on `fetch_addr_o` one cycle after the boundary that caused it. Every single-step address check therefore pins the fault to a single cycle, and the full wrap sweep covers every counter value. A stuck or lost in-service flag shows up as a missing or extra `push_o` at the next boundary where an enabled interrupt is offered. A lost or never-cleared timer-pending flag shows up as an absent or repeated jump to 7 at the first boundary after the service returns.

// File: rtl/pcvs_pkg.sv
`timescale 1ns/1ps
package pcvs_pkg;
    typedef enum logic [1:0] {
        SEL_SEQ = 2'd0,
        SEL_EXT = 2'd1,
        SEL_TMR = 2'd2
    } pcvs_sel_e;
endpackage

// File: rtl/pcvs_seq_next.sv
`timescale 1ns/1ps
module pcvs_seq_next #(
    parameter int PC_W = 11
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            jump_i,
    input  logic [PC_W-1:0] jump_addr_i,
    output logic [PC_W-1:0] next_o
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    always_comb begin
        if (jump_i) next_o = jump_addr_i;
        else        next_o = pc_i + ONE;   // wraps naturally at 2**PC_W
    end
endmodule

// File: rtl/pcvs_arbiter.sv
`timescale 1ns/1ps
module pcvs_arbiter
    import pcvs_pkg::*;
(
    input  logic      adv_i,
    input  logic      in_svc_i,
    input  logic      ext_irq_i,
    input  logic      ext_en_i,
    input  logic      tmr_pend_i,
    input  logic      tmr_en_i,
    output pcvs_sel_e sel_o
);
    logic open_w;
    logic ext_req_w;
    logic tmr_req_w;

    always_comb begin
        open_w    = adv_i & ~in_svc_i;
        ext_req_w = ext_irq_i & ext_en_i;
        tmr_req_w = tmr_pend_i & tmr_en_i;
        if (open_w && ext_req_w)      sel_o = SEL_EXT;
        else if (open_w && tmr_req_w) sel_o = SEL_TMR;
        else                          sel_o = SEL_SEQ;
    end
endmodule

// File: rtl/pc_vector_seq.sv
`timescale 1ns/1ps
module pc_vector_seq
    import pcvs_pkg::*;
#(
    parameter int              PC_W    = 11,
    parameter logic [PC_W-1:0] EXT_VEC = PC_W'(3),
    parameter logic [PC_W-1:0] TMR_VEC = PC_W'(7)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            jump_i,
    input  logic [PC_W-1:0] jump_addr_i,
    input  logic            ext_irq_i,
    input  logic            ext_en_i,
    input  logic            tmr_ovf_i,
    input  logic            tmr_en_i,
    input  logic            reti_i,
    output logic [PC_W-1:0] fetch_addr_o,
    output logic            push_o,
    output logic [PC_W-1:0] push_addr_o
);
    localparam logic [PC_W-1:0] RST_VEC = '0;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] ret;
        logic            push;
        logic            in_svc;
        logic            tmr_pend;
    } pcvs_state_t;

    pcvs_state_t     st_d, st_q;
    logic [PC_W-1:0] seq_next_w;
    pcvs_sel_e       sel_w;
    logic            svc_q_w;
    logic            pend_q_w;

    assign svc_q_w  = st_q.in_svc;
    assign pend_q_w = st_q.tmr_pend;

    pcvs_seq_next #(.PC_W(PC_W)) u_next (
        .pc_i        (st_q.pc),
        .jump_i      (jump_i),
        .jump_addr_i (jump_addr_i),
        .next_o      (seq_next_w)
    );

    pcvs_arbiter u_arb (
        .adv_i      (adv_i),
        .in_svc_i   (svc_q_w),
        .ext_irq_i  (ext_irq_i),
        .ext_en_i   (ext_en_i),
        .tmr_pend_i (pend_q_w),
        .tmr_en_i   (tmr_en_i),
        .sel_o      (sel_w)
    );

    always_comb begin
        st_d          = st_q;
        st_d.push     = 1'b0;
        st_d.tmr_pend = (st_q.tmr_pend & (sel_w != SEL_TMR)) | tmr_ovf_i;
        if (reti_i) st_d.in_svc = 1'b0;
        if (adv_i) begin
            unique case (sel_w)
                SEL_EXT: begin
                    st_d.pc     = EXT_VEC;
                    st_d.ret    = seq_next_w;
                    st_d.push   = 1'b1;
                    st_d.in_svc = 1'b1;
                end
                SEL_TMR: begin
                    st_d.pc     = TMR_VEC;
                    st_d.ret    = seq_next_w;
                    st_d.push   = 1'b1;
                    st_d.in_svc = 1'b1;
                end
                default: st_d.pc = seq_next_w;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc       <= RST_VEC;
            st_q.ret      <= '0;
            st_q.push     <= 1'b0;
            st_q.in_svc   <= 1'b0;
            st_q.tmr_pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr_o = st_q.pc;
    assign push_o       = st_q.push;
    assign push_addr_o  = st_q.ret;
endmodule

// File: rtl/pcvs_chk.sv
`timescale 1ns/1ps
module pcvs_chk #(
    parameter int              PC_W    = 11,
    parameter logic [PC_W-1:0] EXT_VEC = PC_W'(3),
    parameter logic [PC_W-1:0] TMR_VEC = PC_W'(7)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            adv_i,
    input logic            jump_i,
    input logic [PC_W-1:0] jump_addr_i,
    input logic            ext_irq_i,
    input logic            ext_en_i,
    input logic            tmr_en_i,
    input logic [PC_W-1:0] fetch_addr_o,
    input logic            push_o,
    input logic [PC_W-1:0] push_addr_o,
    input logic            in_svc,
    input logic            tmr_pend
);
    logic ext_take, tmr_take;
    assign ext_take = adv_i && !in_svc && ext_irq_i && ext_en_i;
    assign tmr_take = adv_i && !in_svc && tmr_pend && tmr_en_i && !(ext_irq_i && ext_en_i);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_VEC: assert (fetch_addr_o == '0 && !push_o); // R1
        end
    end

    AST_SEQ_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !jump_i) |=> (push_o || fetch_addr_o == $past(fetch_addr_o) + PC_W'(1))); // R2

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && jump_i) |=> (push_o || fetch_addr_o == $past(jump_addr_i))); // R3

    AST_EXT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ext_take |=> (fetch_addr_o == EXT_VEC && push_o)); // R4

    AST_TMR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_take |=> (fetch_addr_o == TMR_VEC && push_o && !tmr_pend)); // R5

    AST_PUSH_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_take || tmr_take) |=>
            (push_addr_o == $past(jump_i ? jump_addr_i : fetch_addr_o + PC_W'(1)))); // R6

    AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_take && tmr_pend && tmr_en_i) |=> (fetch_addr_o == EXT_VEC && tmr_pend)); // R7

    AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc |=> !push_o); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> (!push_o && $stable(fetch_addr_o))); // R9
endmodule

bind pc_vector_seq pcvs_chk #(
    .PC_W    (PC_W),
    .EXT_VEC (EXT_VEC),
    .TMR_VEC (TMR_VEC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_i        (adv_i),
    .jump_i       (jump_i),
    .jump_addr_i  (jump_addr_i),
    .ext_irq_i    (ext_irq_i),
    .ext_en_i     (ext_en_i),
    .tmr_en_i     (tmr_en_i),
    .fetch_addr_o (fetch_addr_o),
    .push_o       (push_o),
    .push_addr_o  (push_addr_o),
    .in_svc       (svc_q_w),
    .tmr_pend     (pend_q_w)
);

// File: tb/sim_pc_vector_seq.sv
`timescale 1ns/1ps
module sim_pc_vector_seq;
    localparam int W = 11;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         adv, jmp, ext, een, ovf, ten, reti;
    logic [W-1:0] ja;
    logic [W-1:0] fetch, paddr;
    logic         push;
    int           nvec = 0;
    int           nerr = 0;

    always #2 clk = ~clk;

    pc_vector_seq u0 (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .jump_i(jmp), .jump_addr_i(ja),
        .ext_irq_i(ext), .ext_en_i(een), .tmr_ovf_i(ovf), .tmr_en_i(ten),
        .reti_i(reti), .fetch_addr_o(fetch), .push_o(push), .push_addr_o(paddr)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, return at next negedge (outputs settled)
    task automatic go(input logic a, input logic j, input int jaddr,
                      input logic e, input logic ee, input logic o,
                      input logic te, input logic r);
        adv = a; jmp = j; ja = W'(jaddr); ext = e; een = ee;
        ovf = o; ten = te; reti = r;
        @(negedge clk);
    endtask

    // expect fetch, push and (when pushing) return address
    task automatic exp_st(input string req, input int pc, input logic p, input int ra);
        chk({req, " fetch"}, int'(fetch), pc);
        chk({req, " push"}, int'(push), int'(p));
        if (p) chk({req, " push_addr"}, int'(paddr), ra);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        adv = 0; jmp = 0; ja = '0; ext = 0; een = 0; ovf = 0; ten = 0; reti = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        exp_st("R1 in reset", 0, 1'b0, 0);
        rst_n = 1'b1;
        go(0, 0, 0, 0, 0, 0, 0, 0);
        exp_st("R1 after release", 0, 1'b0, 0);

        // R2: full sweep with wrap 2047 -> 0
        for (int i = 1; i <= 2048; i++) begin
            go(1, 0, 0, 0, 0, 0, 0, 0);
            chk("R2 sequential", int'(fetch), i % 2048);
        end

        // R9: no boundary - hold, ext ignored, overflow latched but not taken
        go(0, 0, 0, 1, 1, 1, 0, 0);
        exp_st("R9 hold ext", 0, 1'b0, 0);
        go(0, 0, 0, 0, 0, 0, 1, 0);
        exp_st("R9 hold pending", 0, 1'b0, 0);
        // R5: pending timer taken at the next boundary, return = 1
        go(1, 0, 0, 0, 0, 0, 1, 0);
        exp_st("R5 timer entry", 7, 1'b1, 1);
        // R8: in service, external request refused
        go(1, 0, 0, 1, 1, 0, 1, 0);
        exp_st("R8 nest blocked", 8, 1'b0, 0);
        // R8: reti cycle itself still blocks; return via jump to 300
        go(1, 1, 300, 1, 1, 0, 1, 1);
        exp_st("R8 reti cycle", 300, 1'b0, 0);
        // R5: pending cleared after being taken
        go(1, 0, 0, 0, 0, 0, 1, 0);
        exp_st("R5 pend cleared", 301, 1'b0, 0);

        // R3: jump sweep
        for (int t = 5; t < 2048; t += 97) begin
            go(1, 1, t, 0, 0, 0, 0, 0);
            exp_st("R3 jump", t, 1'b0, 0);
        end
        go(1, 1, 100, 0, 0, 0, 0, 0);
        exp_st("R3 jump 100", 100, 1'b0, 0);

        // R4: external with enable low ignored
        go(1, 0, 0, 1, 0, 0, 0, 0);
        exp_st("R4 ext disabled", 101, 1'b0, 0);
        // R4/R6: external taken, return 102
        go(1, 0, 0, 1, 1, 0, 0, 0);
        exp_st("R4 ext entry", 3, 1'b1, 102);
        // R6: push lasts one cycle; R8 timer overflow during service not taken
        go(1, 0, 0, 0, 0, 1, 1, 0);
        exp_st("R6 push one cycle", 4, 1'b0, 0);
        go(1, 1, 400, 0, 0, 0, 1, 1);
        exp_st("R8 return", 400, 1'b0, 0);
        // R5/R6: timer pending from service time now taken, return 401
        go(1, 0, 0, 0, 0, 0, 1, 0);
        exp_st("R5 deferred timer", 7, 1'b1, 401);
        go(1, 1, 500, 0, 0, 0, 0, 1);
        exp_st("R8 return 500", 500, 1'b0, 0);

        // R5: timer pending held while disabled
        go(0, 0, 0, 0, 0, 1, 0, 0);
        go(1, 0, 0, 0, 0, 0, 0, 0);
        exp_st("R5 disabled hold", 501, 1'b0, 0);
        // R7: both at once - external first
        go(1, 0, 0, 1, 1, 0, 1, 0);
        exp_st("R7 ext wins", 3, 1'b1, 502);
        go(1, 1, 600, 0, 0, 0, 1, 1);
        exp_st("R7 return", 600, 1'b0, 0);
        go(1, 0, 0, 0, 0, 0, 1, 0);
        exp_st("R7 timer kept", 7, 1'b1, 601);
        go(1, 1, 2047, 0, 0, 0, 0, 1);
        exp_st("R3 jump top", 2047, 1'b0, 0);

        // R6: jump at an interrupt boundary - return = jump target
        go(1, 1, 1000, 1, 1, 0, 0, 0);
        exp_st("R6 ret is target", 3, 1'b1, 1000);
        // R6: return wraps at top: from 2047 the return address is 0
        go(1, 1, 2047, 0, 0, 0, 0, 1);
        go(1, 0, 0, 1, 1, 0, 0, 0);
        exp_st("R6 ret wraps", 3, 1'b1, 0);

        // R1: reset mid-service clears service state and pending
        go(0, 0, 0, 0, 0, 1, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        exp_st("R1 mid reset", 0, 1'b0, 0);
        rst_n = 1'b1;
        go(1, 0, 0, 0, 0, 0, 1, 0);
        exp_st("R1 pend cleared", 1, 1'b0, 0);
        go(1, 0, 0, 1, 1, 0, 0, 0);
        exp_st("R1 svc cleared", 3, 1'b1, 2);

        go(0, 0, 0, 0, 0, 0, 0, 0);
        summary();
    end
endmodule